// File: doc/BRIEF.md
# Early-Late Symbol Timing Loop

This block recovers symbol timing for a binary antipodal baseband stream, such as the in-phase branch of a quadrature receiver. It sits after a matched filter and accepts one signed filter output per handshake. A down-counter decrements on every accepted sample. The three samples taken at counter values 3, 2 and 1 are, in arrival order, the early sample, the on-time sample and the late sample. The on-time sample is the symbol estimate that goes to a downstream slicer.

Each symbol produces a timing error term equal to the on-time sample times the late sample minus the early sample. These terms add into a wide running sum. The spacing to the next on-time sample stays at the nominal period until the magnitude of the sum rises strictly above a programmable threshold. At that point the spacing is stretched or shortened by one sample and the sum is cleared. A positive sum means the on-time sample sits ahead of the filter peak. A negative sum means it trails the peak.

The input and the output are both valid/ready streams. The block emits at most one symbol per symbol window. It holds a pending symbol until the consumer takes it, and it deasserts `in_ready` while that symbol is pending, so no sample is dropped or counted twice. The threshold and the two slip flags are plain signals.

Top module: `sym_timing_loop`

## Requirements
- R1: After reset, `out_valid`, `slip_fwd` and `slip_back` are 0 and `in_ready` is 1. The counter holds the nominal period of 16, so accepted samples 13, 14 and 15 (counting from 0) are the first early, on-time and late samples.
- R2: The counter decrements once per accepted sample and reloads after the sample taken at count 1. The gap between consecutive on-time samples therefore equals the reload value: 15, 16 or 17.
- R3: The per-symbol error term is on_time*(late-early) at full 33-bit signed precision. It is added to a 40-bit signed running sum, so full-scale inputs (for example early -32768, on-time and late 32767) do not wrap.
- R4: If the updated sum is strictly greater than the unsigned `threshold`, the next gap is 17, `slip_fwd` is 1 for that symbol, and the sum is cleared.
- R5: If the updated sum is strictly less than minus `threshold`, the next gap is 15, `slip_back` is 1 for that symbol, and the sum is cleared.
- R6: Otherwise the next gap is 16, both flags are 0, and the sum is kept for later symbols. A sum equal to plus or minus `threshold` causes no slip.
- R7: One cycle after the late sample is accepted, `out_valid` rises with `out_data` equal to the on-time sample. `slip_fwd` and `slip_back` update in the same cycle and are never both 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold and `in_ready` is 0. Samples offered during the stall are accepted only after the handshake, and no sample is lost.
- R9: For a triangular matched-filter waveform with a 32-sample period and peaks of +/-8000, the on-time samples settle on the positive and negative peaks within 40 symbols, from any start offset whose first on-time sample is not a zero crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Matched-filter sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 16 | Signed matched-filter sample |
| threshold | input | 32 | Unsigned slip threshold on the running sum |
| out_valid | output | 1 | On-time symbol sample pending |
| out_ready | input | 1 | Consumer takes the pending symbol |
| out_data | output | 16 | Signed on-time sample |
| slip_fwd | output | 1 | This symbol lengthened the next gap |
| slip_back | output | 1 | This symbol shortened the next gap |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a period of 16, a 40-bit sum and a 32-bit threshold. With 16-bit samples, a full-scale error term near 2^31 can be driven directly. Threshold values of 0 and 100 put the strict comparison exactly on its boundary, from both signs. The period of 16 lets a 32-sample triangle carry one positive and one negative peak per pair of symbols, so locking onto both peaks is covered by a few hundred samples per offset.

// File: rtl/stl_pkg.sv
package stl_pkg;
  typedef enum logic [1:0] {
    SP_NOM   = 2'd0,
    SP_LONG  = 2'd1,
    SP_SHORT = 2'd2
  } spacing_e;
endpackage

// File: rtl/stl_counter.sv
module stl_counter
  import stl_pkg::*;
#(
  parameter int TSYMB = 16,
  localparam int CNT_W = $clog2(TSYMB + 2)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  spacing_e spacing,
  output logic     at_first,
  output logic     at_on,
  output logic     at_last
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  always_comb begin
    case (spacing)
      SP_LONG:  reload = CNT_W'(TSYMB + 1);
      SP_SHORT: reload = CNT_W'(TSYMB - 1);
      default:  reload = CNT_W'(TSYMB);
    endcase
  end

  assign at_first = (cnt == CNT_W'(3));
  assign at_on    = (cnt == CNT_W'(2));
  assign at_last  = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= CNT_W'(TSYMB);
    else if (step)    cnt <= at_last ? reload : cnt - 1'b1;
  end

  // R2: the count never leaves 1..TSYMB+1
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(TSYMB + 1)));
  // R2: no accepted sample, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  // R4: a forward slip reloads the long gap
  a_r4_long: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_last && spacing == SP_LONG |=> cnt == CNT_W'(TSYMB + 1));
  // R5: a backward slip reloads the short gap
  a_r5_short: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_last && spacing == SP_SHORT |=> cnt == CNT_W'(TSYMB - 1));
  // R6: no slip reloads the nominal gap
  a_r6_nom: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_last && spacing == SP_NOM |=> cnt == CNT_W'(TSYMB));
endmodule

// File: rtl/stl_capture.sv
module stl_capture #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic                       at_first,
  input  logic                       at_on,
  input  logic signed [SAMPLE_W-1:0] in_data,
  output logic signed [SAMPLE_W-1:0] early_q,
  output logic signed [SAMPLE_W-1:0] on_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      early_q <= '0;
      on_q    <= '0;
    end else if (step) begin
      if (at_first) early_q <= in_data;
      if (at_on)    on_q    <= in_data;
    end
  end
endmodule

// File: rtl/stl_decide.sv
module stl_decide
  import stl_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 40,
  parameter int TH_W     = 32,
  localparam int PROD_W  = 2 * SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eval,
  input  logic signed [SAMPLE_W-1:0] early,
  input  logic signed [SAMPLE_W-1:0] on_s,
  input  logic signed [SAMPLE_W-1:0] late,
  input  logic        [TH_W-1:0]     threshold,
  output spacing_e                   spacing
);
  logic signed [PROD_W-1:0] on_x, diff_x, prod;
  logic signed [ACC_W-1:0]  acc, sum_next, th_x;
  logic                     ahead, behind;

  assign on_x     = {{(PROD_W - SAMPLE_W){on_s[SAMPLE_W-1]}}, on_s};
  assign diff_x   = {{(PROD_W - SAMPLE_W){late[SAMPLE_W-1]}}, late}
                  - {{(PROD_W - SAMPLE_W){early[SAMPLE_W-1]}}, early};
  assign prod     = on_x * diff_x;
  assign sum_next = acc + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign th_x     = $signed({{(ACC_W - TH_W){1'b0}}, threshold});
  assign ahead    = sum_next > th_x;
  assign behind   = sum_next < -th_x;
  assign spacing  = ahead ? SP_LONG : (behind ? SP_SHORT : SP_NOM);

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (eval) acc <= (ahead || behind) ? '0 : sum_next;
  end

  // R4/R5: every slip leaves a cleared sum
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    eval && spacing != SP_NOM |=> acc == '0);
  // R6: without an evaluation the sum is kept
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(acc));
endmodule

// File: rtl/sym_timing_loop.sv
module sym_timing_loop
  import stl_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int TSYMB    = 16,
  parameter int ACC_W    = 40,
  parameter int TH_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [TH_W-1:0]     threshold,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                slip_fwd,
  output logic                slip_back
);
  logic                       step, at_first, at_on, at_last, emit;
  logic signed [SAMPLE_W-1:0] early_q, on_q;
  spacing_e                   spacing;

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;
  assign emit     = step && at_last;

  stl_counter #(.TSYMB(TSYMB)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .spacing(spacing),
    .at_first(at_first), .at_on(at_on), .at_last(at_last)
  );

  stl_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .step(step), .at_first(at_first),
    .at_on(at_on), .in_data($signed(in_data)),
    .early_q(early_q), .on_q(on_q)
  );

  stl_decide #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .TH_W(TH_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .eval(emit), .early(early_q), .on_s(on_q),
    .late($signed(in_data)), .threshold(threshold), .spacing(spacing)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      slip_fwd  <= 1'b0;
      slip_back <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= on_q;
      slip_fwd  <= (spacing == SP_LONG);
      slip_back <= (spacing == SP_SHORT);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a refused symbol stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8: nothing enters while the output is blocked
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(slip_fwd) && $stable(slip_back));
  // R7: the two slip flags exclude each other
  a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slip_fwd, slip_back}));
endmodule

// File: tb/tb_sym_timing_loop.sv
module tb_sym_timing_loop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [31:0] threshold = 32'd100;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        slip_fwd, slip_back;

  int n_run = 0, n_fail = 0;
  int ev_n = 0;
  int ev_data [0:255];
  bit ev_fwd  [0:255];
  bit ev_back [0:255];

  always #5 clk = ~clk;

  sym_timing_loop dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .threshold(threshold), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .slip_fwd(slip_fwd),
    .slip_back(slip_back)
  );

  // stimulus/expected table: early, on-time, late, threshold, expected gap
  localparam int ROWS = 10;
  localparam int TV_E  [ROWS] = '{10, 30, 10, 10, 10, 20, -32768, 0, 30, 30};
  localparam int TV_O  [ROWS] = '{20, 20, -20, 5, 5, 50, 32767, 1, 5, 5};
  localparam int TV_L  [ROWS] = '{30, 10, 30, 30, 31, 20, 32767, 1, 10, 9};
  localparam int TV_TH [ROWS] = '{100, 100, 100, 100, 100, 100, 100, 0, 100, 100};
  localparam int TV_GAP[ROWS] = '{17, 15, 15, 16, 17, 16, 17, 17, 16, 15};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ev_n = 0;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(v);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    if (out_valid && out_ready && ev_n < 256) begin
      ev_data[ev_n] = int'($signed(out_data));
      ev_fwd[ev_n]  = slip_fwd;
      ev_back[ev_n] = slip_back;
      ev_n++;
    end
  endtask

  function automatic int tri_wave(input int n, input int off);
    int p;
    p = (n + off) % 32;
    return 8000 - 1000 * ((p >= 16) ? p - 16 : 16 - p);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk({slip_fwd, slip_back} == 2'b00, "R1 flags", {slip_fwd, slip_back}, 0);

    // R2..R7: table walk, one isolated symbol per row, then gap measurement
    for (int r = 0; r < ROWS; r++) begin
      do_reset();
      threshold = TV_TH[r];
      for (int i = 0; i < 40; i++) begin
        int v;
        if (i == 13)      v = TV_E[r];
        else if (i == 14) v = TV_O[r];
        else if (i == 15) v = TV_L[r];
        else if (i < 13)  v = 0;
        else              v = 1000 + i;
        push(v);
        if (i == 15) chk(out_valid == 1'b1, "R7 valid after late", out_valid, 1);
      end
      chk(ev_n >= 2, "R2 symbols seen", ev_n, 2);
      chk(ev_data[0] == TV_O[r], "R7 on-time data", ev_data[0], TV_O[r]);
      chk(ev_fwd[0] == (TV_GAP[r] == 17), "R4 slip_fwd", ev_fwd[0], TV_GAP[r] == 17);
      chk(ev_back[0] == (TV_GAP[r] == 15), "R5 slip_back", ev_back[0], TV_GAP[r] == 15);
      // R2/R3/R6: second on-time sample lands at index 14+gap
      chk(ev_data[1] == 1014 + TV_GAP[r], "R2 R3 R6 gap", ev_data[1], 1014 + TV_GAP[r]);
    end

    // R6 then R4: accumulation over symbols and clearing after a slip
    do_reset();
    threshold = 1000;
    for (int i = 0; i < 82; i++) begin
      int v;
      v = 0;
      if (i == 14 || i == 30 || i == 46 || i == 63 || i == 79) v = 20;
      if (i == 13 || i == 29 || i == 45 || i == 62 || i == 78) v = 10;
      if (i == 15 || i == 31 || i == 47 || i == 64 || i == 80) v = 30;
      push(v);
    end
    chk(ev_n == 5, "R6 accum symbol count", ev_n, 5);
    chk(!ev_fwd[0] && !ev_fwd[1], "R6 sum below threshold keeps gap", ev_fwd[1], 0);
    chk(ev_fwd[2] == 1'b1, "R4 sum 1200 over 1000 slips", ev_fwd[2], 1);
    chk(ev_data[3] == 20, "R4 gap 17 after slip", ev_data[3], 20);
    chk(ev_fwd[3] == 1'b0, "R4 sum cleared after slip", ev_fwd[3], 0);
    chk(ev_data[4] == 20 && !ev_back[4], "R6 nominal after clear", ev_data[4], 20);

    // R8: back-pressure
    do_reset();
    threshold = 100;
    out_ready = 1'b0;
    for (int i = 0; i < 16; i++) push((i >= 13) ? 7 : 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'd1016;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      chk(in_ready == 1'b0, "R8 in_ready low", in_ready, 0);
      chk(out_valid == 1'b1 && out_data == 16'd7, "R8 data held", out_data, 7);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R8 handshake clears", out_valid, 0);
    ev_n = 0;
    for (int i = 17; i < 32; i++) push(1000 + i);
    chk(ev_n == 1 && ev_data[0] == 1030, "R8 no sample lost", ev_data[0], 1030);

    // R9: lock on a 32-sample triangle from two offsets
    for (int t = 0; t < 2; t++) begin
      int off;
      off = (t == 0) ? 5 : 22;
      do_reset();
      threshold = 1000;
      for (int i = 0; i < 1600; i++) push(tri_wave(i, off));
      chk(ev_n >= 90, "R9 symbol count", ev_n, 90);
      for (int k = 40; k < 90; k++)
        chk(ev_data[k] == 8000 || ev_data[k] == -8000, "R9 on peak", ev_data[k], 8000);
    end

    @(negedge clk);
    in_valid = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule